// File: doc/BRIEF.md
# Masked Control Register Bank

This block holds the privileged control registers of a processor core. The issue pipeline reaches it through one port: a 6-bit index, a read strobe and a write strobe. Reads are combinational and writes commit on the clock edge. Each index has its own write rule:

- plain 64-bit storage;
- storage that keeps only a fixed set of bits;
- a register that any write clears;
- a register that can be written only once;
- read-only or write-only access.

A bad access is reported on an error line as a single-cycle pulse. One register is a cycle register. Its read value takes the upper half from storage and the lower half from a counter that runs freely.

The reset values are fixed, with three exceptions. The vector base and one scratch register load parameter values, and the mode-control register loads 0x6. Side effects of the flush and invalidate controls belong to other blocks. This bank only decodes those indices and accepts the writes.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset these registers read as follows: vector base (index 8) returns parameter VEC_BASE_RST, mode control (index 9) returns 0x6, scratch 7 (index 7) returns parameter CPU_ID, all other readable registers return zero, and acc_err is 0.
- R2: Scratch 0..7 (indices 0..7), vector base (8) and mode control (9) store all 64 written bits.
- R3: A write to the trap-PC register (index 10) stores the value with bit 1 cleared.
- R4: Write masks: trap enable (11) and trap request (12) keep 0xf; priority level (13) keeps 0x1f; current mode (14) and alternate mode (15) keep 0x18.
- R5: Write masks: software-interrupt request (16) keeps 0x7fff0; core control/status (17) keeps 0xff_ffff_0300; the two page-table bases (18, 19) keep 0xffff_ffff_c000_0000; the two mode registers (20, 21) keep 0x3f; cache test (22) keeps 0x1ffb.
- R6: Any write to the exception summary (23) or exception mask (24) leaves the register at zero.
- R7: A read of the cycle register (25) returns stored bits [63:32] over a 32-bit counter that steps by one on every clock. A write stores all 64 bits, but only the upper half is visible.
- R8: The cycle-control register (26) becomes 1 on its first write, whatever the data. Every later write raises the error and leaves it at 1.
- R9: Writes to the read-only registers (27, 28) raise the error and leave them at zero. Reads of the write-only controls (29..32) raise the error. Writes to the write-only controls are accepted without error.
- R10: Any read or write of an unassigned index (33..63) raises the error.
- R11: acc_err is high for exactly the one cycle after the clock edge that samples an illegal access. rdata is zero when rd_en is low or the read is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, committed on the rising edge |
| idx | input | 6 | Register index |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Combinational read data |
| acc_err | output | 1 | Registered one-cycle illegal-access pulse |

## Verification
The assertions assume three things about the inputs:

- the strobes are driven to known values from time zero;
- the strobes stay low while reset is held;
- idx and the strobes are stable around each rising edge.

The bench meets these by driving every input only on the falling edge and holding both strobes low through reset and its synchronous release. The cycle-counter step property assumes that two back-to-back reads of index 25 are a clock apart. The bench issues such reads only through its one-cycle read task, so this holds.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 64;
  localparam int CYC_W  = 32;

  localparam logic [IDX_W-1:0] RI_SCR0     = 6'd0;
  localparam logic [IDX_W-1:0] RI_SCR_ID   = 6'd7;
  localparam logic [IDX_W-1:0] RI_VBASE    = 6'd8;
  localparam logic [IDX_W-1:0] RI_MODECTL  = 6'd9;
  localparam logic [IDX_W-1:0] RI_TRAPPC   = 6'd10;
  localparam logic [IDX_W-1:0] RI_TRAPEN   = 6'd11;
  localparam logic [IDX_W-1:0] RI_TRAPRQ   = 6'd12;
  localparam logic [IDX_W-1:0] RI_PRIO     = 6'd13;
  localparam logic [IDX_W-1:0] RI_CURMODE  = 6'd14;
  localparam logic [IDX_W-1:0] RI_ALTMODE  = 6'd15;
  localparam logic [IDX_W-1:0] RI_SWIRQ    = 6'd16;
  localparam logic [IDX_W-1:0] RI_CORECSR  = 6'd17;
  localparam logic [IDX_W-1:0] RI_IPTBASE  = 6'd18;
  localparam logic [IDX_W-1:0] RI_DPTBASE  = 6'd19;
  localparam logic [IDX_W-1:0] RI_CMODE    = 6'd20;
  localparam logic [IDX_W-1:0] RI_MMODE    = 6'd21;
  localparam logic [IDX_W-1:0] RI_CTEST    = 6'd22;
  localparam logic [IDX_W-1:0] RI_EXCSUM   = 6'd23;
  localparam logic [IDX_W-1:0] RI_EXCMSK   = 6'd24;
  localparam logic [IDX_W-1:0] RI_CYC      = 6'd25;
  localparam logic [IDX_W-1:0] RI_CYCCTL   = 6'd26;
  localparam logic [IDX_W-1:0] RI_RO_FIRST = 6'd27;
  localparam logic [IDX_W-1:0] RI_RO_LAST  = 6'd28;
  localparam logic [IDX_W-1:0] RI_WO_FIRST = 6'd29;
  localparam logic [IDX_W-1:0] RI_WO_LAST  = 6'd32;

  localparam int NUM_SLOTS = int'(RI_RO_LAST) + 1;

  typedef enum logic [2:0] {
    AC_RW, AC_RO, AC_WO, AC_ONCE, AC_NONE
  } acc_e;

  function automatic acc_e access_of(input logic [IDX_W-1:0] i);
    if (i == RI_CYCCTL)                           return AC_ONCE;
    if (i >= RI_RO_FIRST && i <= RI_RO_LAST)      return AC_RO;
    if (i >= RI_WO_FIRST && i <= RI_WO_LAST)      return AC_WO;
    if (i > RI_WO_LAST)                           return AC_NONE;
    return AC_RW;
  endfunction

  function automatic logic [DATA_W-1:0] keep_of(input int i);
    case (i)
      int'(RI_TRAPPC):                   return ~64'h2;
      int'(RI_TRAPEN), int'(RI_TRAPRQ):  return 64'hf;
      int'(RI_PRIO):                     return 64'h1f;
      int'(RI_CURMODE), int'(RI_ALTMODE): return 64'h18;
      int'(RI_SWIRQ):                    return 64'h7fff0;
      int'(RI_CORECSR):                  return 64'hff_ffff_0300;
      int'(RI_IPTBASE), int'(RI_DPTBASE): return 64'hffff_ffff_c000_0000;
      int'(RI_CMODE), int'(RI_MMODE):    return 64'h3f;
      int'(RI_CTEST):                    return 64'h1ffb;
      default:                           return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_of(input int i,
      input logic [DATA_W-1:0] vbase, input logic [DATA_W-1:0] cpu_id);
    if (i == int'(RI_VBASE))   return vbase;
    if (i == int'(RI_MODECTL)) return 64'h6;
    if (i == int'(RI_SCR_ID))  return cpu_id;
    return '0;
  endfunction
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
(
  input  logic [IDX_W-1:0]     idx,
  output acc_e                 cls,
  output logic [NUM_SLOTS-1:0] sel
);
  always_comb begin
    cls = access_of(idx);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      sel[i] = (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/ctlreg_cyc.sv
module ctlreg_cyc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_r, cnt_nx;

  always_comb cnt_nx = cnt_r + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_nx;
  end

  assign cnt = cnt_r;
endmodule

// File: rtl/ctlreg_slot.sv
module ctlreg_slot #(
  parameter int         W       = 64,
  parameter logic [W-1:0] KEEP    = '1,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit         CLEARS  = 1'b0,
  parameter bit         ONCE    = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nx;

  always_comb begin
    if (CLEARS)    q_nx = '0;
    else if (ONCE) q_nx = W'(1);
    else           q_nx = d & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST_VAL;
    else if (we) q_r <= q_nx;
  end

  assign q = q_r;

  // R4 / R5: bits outside the keep mask never survive a write
  a_r5_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q_r & ~KEEP) == '0));
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter logic [63:0] VEC_BASE_RST = 64'h0000_0000_0000_8000,
  parameter logic [63:0] CPU_ID       = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_err
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'({CYC_W{1'b1}});

  // asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  acc_e                 cls;
  logic [NUM_SLOTS-1:0] sel;
  logic [CYC_W-1:0]     cyc_cnt;
  logic [DATA_W-1:0]    slot_q [NUM_SLOTS];
  logic                 once_used, wr_ok, rd_ok, err_nx, err_q;

  ctlreg_decode u_dec (.idx(idx), .cls(cls), .sel(sel));

  ctlreg_cyc #(.W(CYC_W)) u_cyc (.clk(clk), .rst_n(rst_s), .cnt(cyc_cnt));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
      ctlreg_slot #(
        .W      (DATA_W),
        .KEEP   (keep_of(gi)),
        .RST_VAL(reset_of(gi, VEC_BASE_RST, CPU_ID)),
        .CLEARS (gi == int'(RI_EXCSUM) || gi == int'(RI_EXCMSK)),
        .ONCE   (gi == int'(RI_CYCCTL))
      ) u_slot (
        .clk  (clk),
        .rst_n(rst_s),
        .we   (wr_ok && sel[gi]),
        .d    (wdata),
        .q    (slot_q[gi])
      );
    end
  endgenerate

  assign once_used = slot_q[RI_CYCCTL][0];

  always_comb begin
    wr_ok = wr_en && (cls == AC_RW || (cls == AC_ONCE && !once_used));
    rd_ok = rd_en && (cls != AC_WO) && (cls != AC_NONE);
    err_nx = (wr_en && (cls == AC_RO || cls == AC_NONE ||
                        (cls == AC_ONCE && once_used)))
          || (rd_en && (cls == AC_WO || cls == AC_NONE));
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (sel[i]) rdata = slot_q[i];
      end
      if (idx == RI_CYC) rdata = (rdata & ~LOW_MASK) | DATA_W'(cyc_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_nx;
  end

  assign acc_err = err_q;

  a_r3_trap_bit1: assert property (@(posedge clk) disable iff (!rst_s)
    !slot_q[RI_TRAPPC][1]);

  a_r6_clear_on_write: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && (idx == RI_EXCSUM || idx == RI_EXCMSK)) |=> (rdata == '0 || !rd_en || idx != $past(idx)));

  a_r8_once_value: assert property (@(posedge clk) disable iff (!rst_s)
    slot_q[RI_CYCCTL] <= DATA_W'(1));

  a_r8_once_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    once_used |=> once_used);

  a_r10_unassigned: assert property (@(posedge clk) disable iff (!rst_s)
    ((rd_en || wr_en) && idx > RI_WO_LAST) |=> acc_err);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_en |-> (rdata == '0));

  a_r7_cyc_step: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_en && idx == RI_CYC && $past(rd_en) && $past(idx) == RI_CYC && $past(rst_s))
      |-> (rdata[CYC_W-1:0] == $past(rdata[CYC_W-1:0]) + CYC_W'(1)));
endmodule

// File: tb/ctlreg_bank_test.sv
module ctlreg_bank_test;
  localparam logic [63:0] VB  = 64'h0000_0000_0001_0000;
  localparam logic [63:0] CID = 64'h5;
  localparam int NV = 17;

  // {index, write data, expected readback}
  localparam logic [133:0] VECS [NV] = '{
    {6'd0,  64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff},  // R2
    {6'd3,  64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef},  // R2
    {6'd8,  64'h0000_0000_dead_beef, 64'h0000_0000_dead_beef},  // R2
    {6'd10, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffd},  // R3
    {6'd11, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_000f},  // R4
    {6'd12, 64'h0000_0000_0000_005a, 64'h0000_0000_0000_000a},  // R4
    {6'd13, 64'h0000_0000_0000_ffff, 64'h0000_0000_0000_001f},  // R4
    {6'd14, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_0018},  // R4
    {6'd15, 64'h0000_0000_0000_000f, 64'h0000_0000_0000_0008},  // R4
    {6'd16, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0007_fff0},  // R5
    {6'd17, 64'hffff_ffff_ffff_ffff, 64'h0000_00ff_ffff_0300},  // R5
    {6'd18, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_c000_0000},  // R5
    {6'd19, 64'h1234_5678_9abc_def0, 64'h1234_5678_8000_0000},  // R5
    {6'd20, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_003f},  // R5
    {6'd21, 64'h0000_0000_0000_0123, 64'h0000_0000_0000_0023},  // R5
    {6'd22, 64'h0000_0000_0000_ffff, 64'h0000_0000_0000_1ffb},  // R5
    {6'd10, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0000}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  idx = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        acc_err;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctlreg_bank #(.VEC_BASE_RST(VB), .CPU_ID(CID)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .idx(idx), .wdata(wdata), .rdata(rdata), .acc_err(acc_err));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [63:0] d);
    idx = i; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] i, output logic [63:0] d);
    idx = i; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    check("R1 err", {63'b0, acc_err}, 64'h0);
    rd(6'd8, v);  check("R1 vector base", v, VB);
    rd(6'd9, v);  check("R1 mode control", v, 64'h6);
    rd(6'd7, v);  check("R1 cpu id scratch", v, CID);
    rd(6'd0, v);  check("R1 scratch 0", v, 64'h0);
    rd(6'd17, v); check("R1 core csr", v, 64'h0);

    // R2..R5 table walk
    for (int k = 0; k < NV; k++) begin
      wr(VECS[k][133:128], VECS[k][127:64]);
      check("R2-5 write err", {63'b0, acc_err}, 64'h0);
      rd(VECS[k][133:128], v);
      check("R2/R3/R4/R5 readback", v, VECS[k][63:0]);
    end

    // R6 clear on write
    wr(6'd23, 64'hffff_ffff_ffff_ffff); rd(6'd23, v); check("R6 exc summary", v, 64'h0);
    wr(6'd24, 64'h1234);                rd(6'd24, v); check("R6 exc mask", v, 64'h0);

    // R7 cycle register
    rd(6'd25, a);
    repeat (9) @(negedge clk);
    rd(6'd25, b);
    check("R7 counter step", {32'b0, b[31:0] - a[31:0]}, 64'd10);
    wr(6'd25, 64'haaaa_5555_0000_1111);
    rd(6'd25, v);
    check("R7 upper half stored", {v[63:32], 32'b0}, 64'haaaa_5555_0000_0000);

    // R8 write once
    rd(6'd26, v); check("R8 before", v, 64'h0);
    wr(6'd26, 64'h0); check("R8 first write err", {63'b0, acc_err}, 64'h0);
    rd(6'd26, v); check("R8 holds 1", v, 64'h1);
    wr(6'd26, 64'hff); check("R8 second write err", {63'b0, acc_err}, 64'h1);
    rd(6'd26, v); check("R8 still 1", v, 64'h1);

    // R9 read-only and write-only
    wr(6'd27, 64'hffff); check("R9 ro write err", {63'b0, acc_err}, 64'h1);
    rd(6'd27, v); check("R9 ro unchanged", v, 64'h0);
    check("R11 err pulse drops", {63'b0, acc_err}, 64'h0);
    wr(6'd28, 64'h1); rd(6'd28, v); check("R9 ro 28 unchanged", v, 64'h0);
    wr(6'd30, 64'h77); check("R9 wo write ok", {63'b0, acc_err}, 64'h0);
    rd(6'd31, v); check("R9 wo read err", {63'b0, acc_err}, 64'h1);
    check("R11 illegal read data zero", v, 64'h0);

    // R10 unassigned
    @(negedge clk);
    wr(6'd40, 64'h1); check("R10 write err", {63'b0, acc_err}, 64'h1);
    rd(6'd63, v); check("R10 read err", {63'b0, acc_err}, 64'h1);
    check("R10 read data zero", v, 64'h0);

    // R11 idle: one-cycle pulse and zero data
    @(negedge clk);
    check("R11 pulse one cycle", {63'b0, acc_err}, 64'h0);
    idx = 6'd8; #1 check("R11 idle rdata", rdata, 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule